// File: doc/BRIEF.md
# Slave Sync Line and Field Tracker

This block follows horizontal and vertical sync signals supplied from outside the chip when the video path runs as a timing slave. The fast input clock runs at twice the pixel sample rate; the block divides it by two into a pixel-rate enable strobe, and every other piece of logic advances only on that strobe. Both sync inputs pass through a two-flop synchronizer, and their falling edges are sampled on the pixel cadence.

Each horizontal falling edge starts a new line and advances a line counter. A new field starts only when the vertical falling edge is seen in the same pixel sample as a horizontal falling edge. At that point the line counter returns to zero and a three-bit field number advances, wrapping from 7 back to 0. Line zero is the first line that carries a vertical serration. Downstream logic gets a five-bit line identifier that saturates at all-ones, the field number, and one-pixel start pulses for each line and each field. While reset is low, a pad drive enable is held low so that the pad ring can float the sync outputs.

All ports are plain control and status pins with no data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `sync_tracker`

## Requirements
- R1: `pix_en` is high on every second `clk2x` cycle. It is low in the first cycle after reset release and alternates from then on.
- R2: A falling edge of `hsync_in` (each level held at least two `clk2x` cycles) adds one to the line count. It also raises `line_start` for exactly one pixel period, which is two `clk2x` cycles.
- R3: When falling edges of `vsync_in` and `hsync_in` are seen in the same pixel sample, the line count becomes 0 and `field_num` advances by one. `field_start` and `line_start` are each raised for one pixel period.
- R4: A `vsync_in` falling edge with no `hsync_in` falling edge in the same pixel sample is ignored: `field_num`, `line_id` and `field_start` are unchanged. This holds even when a `hsync_in` edge follows some pixels later, which then counts as an ordinary line.
- R5: `line_id` equals the line count for counts 0 to 30. It is 5'b11111 for any count of 31 or more.
- R6: `field_num` wraps from 7 to 0 on the next field start.
- R7: While `rst_n` is low, `out_drive_en`, `line_id`, `field_num`, `line_start`, `field_start` and `pix_en` are all 0. After release, `out_drive_en` goes to 1.
- R8: `line_id`, `field_num`, `line_start` and `field_start` change only at edges where `pix_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the pixel rate |
| rst_n | input | 1 | Active-low reset |
| hsync_in | input | 1 | Horizontal sync, falling edge active |
| vsync_in | input | 1 | Vertical sync, falling edge active |
| pix_en | output | 1 | Pixel-rate enable strobe |
| line_id | output | 5 | Line within field, saturating at 31 |
| field_num | output | 3 | Field number, modulo 8 |
| line_start | output | 1 | One-pixel pulse at each line start |
| field_start | output | 1 | One-pixel pulse at each field start |
| out_drive_en | output | 1 | High when the outputs are to be driven by the pads |

## Verification
The bench drives four sync patterns:
- A horizontal edge alone, which must advance the line only.
- Both edges together, which must start a field.
- A vertical edge alone, which must change nothing.
- A vertical edge followed some pixels later by a horizontal edge, which must count as a line and not as a field.

Together these separate true coincidence detection from simple level or ordering checks. Long runs of lines show whether the identifier saturates at 31 rather than wrapping. Repeated field starts show whether the field number wraps from 7 to 0. Pulse widths are measured in clock cycles, which tells a one-pixel pulse apart from a one-clock pulse.

// File: rtl/st_pkg.sv
package st_pkg;
  localparam int LINE_ID_W = 5;
  localparam int FLD_W     = 3;
  localparam logic [LINE_ID_W-1:0] LINE_ID_MAX = '1;

  // index of each sync channel in the synchronizer vector
  localparam int CH_HS = 0;
  localparam int CH_VS = 1;
  localparam int N_CH  = 2;
endpackage

// File: rtl/st_pix_div.sv
module st_pix_div (
  input  logic clk2x,
  input  logic rst_n,
  output logic pix_en
);
  logic phase;

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) phase <= 1'b0;
    else        phase <= ~phase;
  end

  assign pix_en = phase;

  // R1
  pix_alt_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    pix_en |=> !pix_en);
  // R1
  pix_rise_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    !pix_en |=> pix_en);
endmodule

// File: rtl/st_sync_edge.sv
module st_sync_edge #(
  parameter int N = 2
) (
  input  logic         clk2x,
  input  logic         rst_n,
  input  logic         pix_en,
  input  logic [N-1:0] raw,
  output logic [N-1:0] fall
);
  for (genvar i = 0; i < N; i++) begin : g_ch
    logic s1, s2, prev;

    always_ff @(posedge clk2x or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= 1'b1;
        s2 <= 1'b1;
      end else begin
        s1 <= raw[i];
        s2 <= s1;
      end
    end

    always_ff @(posedge clk2x or negedge rst_n) begin
      if (!rst_n)      prev <= 1'b1;
      else if (pix_en) prev <= s2;
    end

    assign fall[i] = pix_en & prev & ~s2;

    // R8
    fall_on_pix_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
      fall[i] |-> pix_en);
  end
endmodule

// File: rtl/st_counters.sv
module st_counters
  import st_pkg::*;
#(
  parameter int LINE_CNT_W = 10
) (
  input  logic                 clk2x,
  input  logic                 rst_n,
  input  logic                 pix_en,
  input  logic                 hs_fall,
  input  logic                 vs_fall,
  output logic [LINE_ID_W-1:0] line_id,
  output logic [FLD_W-1:0]     field_num,
  output logic                 line_start,
  output logic                 field_start
);
  localparam logic [LINE_CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [LINE_CNT_W-1:0] ID_LIMIT = LINE_CNT_W'(LINE_ID_MAX);

  logic [LINE_CNT_W-1:0] line_cnt;
  logic                  fld_edge;

  assign fld_edge = hs_fall & vs_fall;

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) begin
      line_cnt    <= '0;
      field_num   <= '0;
      line_start  <= 1'b0;
      field_start <= 1'b0;
    end else if (pix_en) begin
      line_start  <= hs_fall;
      field_start <= fld_edge;
      if (fld_edge) begin
        line_cnt  <= '0;
        field_num <= field_num + 1'b1;
      end else if (hs_fall && line_cnt != CNT_MAX) begin
        line_cnt  <= line_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    if (line_cnt >= ID_LIMIT) line_id = LINE_ID_MAX;
    else                      line_id = line_cnt[LINE_ID_W-1:0];
  end

  // R3
  fld_adv_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    (pix_en && hs_fall && vs_fall) |=> (field_num == $past(field_num) + 3'd1));
  // R3
  fld_line0_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    field_start |-> (line_id == '0) && line_start);
  // R4
  vs_alone_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    (pix_en && vs_fall && !hs_fall) |=> $stable(field_num) && !field_start);
  // R8
  hold_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    !pix_en |=> $stable(line_id) && $stable(field_num) && $stable(line_start));
endmodule

// File: rtl/sync_tracker.sv
module sync_tracker
  import st_pkg::*;
#(
  parameter int LINE_CNT_W = 10
) (
  input  logic                 clk2x,
  input  logic                 rst_n,
  input  logic                 hsync_in,
  input  logic                 vsync_in,
  output logic                 pix_en,
  output logic [LINE_ID_W-1:0] line_id,
  output logic [FLD_W-1:0]     field_num,
  output logic                 line_start,
  output logic                 field_start,
  output logic                 out_drive_en
);
  logic [N_CH-1:0] raw, fall;

  assign raw[CH_HS] = hsync_in;
  assign raw[CH_VS] = vsync_in;

  st_pix_div u_div (
    .clk2x  (clk2x),
    .rst_n  (rst_n),
    .pix_en (pix_en)
  );

  st_sync_edge #(.N(N_CH)) u_edge (
    .clk2x  (clk2x),
    .rst_n  (rst_n),
    .pix_en (pix_en),
    .raw    (raw),
    .fall   (fall)
  );

  st_counters #(.LINE_CNT_W(LINE_CNT_W)) u_cnt (
    .clk2x       (clk2x),
    .rst_n       (rst_n),
    .pix_en      (pix_en),
    .hs_fall     (fall[CH_HS]),
    .vs_fall     (fall[CH_VS]),
    .line_id     (line_id),
    .field_num   (field_num),
    .line_start  (line_start),
    .field_start (field_start)
  );

  always_ff @(posedge clk2x or negedge rst_n) begin
    if (!rst_n) out_drive_en <= 1'b0;
    else        out_drive_en <= 1'b1;
  end

  // R7
  drive_on_chk: assert property (@(posedge clk2x) disable iff (!rst_n)
    1'b1 |=> out_drive_en);
endmodule

// File: tb/sim_sync_tracker.sv
module sim_sync_tracker;
  logic clk2x = 1'b0;
  logic rst_n = 1'b0;
  logic hs = 1'b1, vs = 1'b1;
  logic pix_en, line_start, field_start, drv;
  logic [4:0] line_id;
  logic [2:0] field_num;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk2x = ~clk2x;

  sync_tracker u0 (
    .clk2x(clk2x), .rst_n(rst_n), .hsync_in(hs), .vsync_in(vs),
    .pix_en(pix_en), .line_id(line_id), .field_num(field_num),
    .line_start(line_start), .field_start(field_start), .out_drive_en(drv)
  );

  // pulse monitor, sampled at falling clock edges
  int ls_rise, ls_hi, fs_rise, fs_hi;
  logic ls_q = 1'b0, fs_q = 1'b0;
  always @(negedge clk2x) begin
    if (line_start)          ls_hi++;
    if (line_start && !ls_q) ls_rise++;
    if (field_start)          fs_hi++;
    if (field_start && !fs_q) fs_rise++;
    ls_q = line_start;
    fs_q = field_start;
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk2x);
  endtask

  // kind 0: hsync edge, 1: both edges together, 2: vsync alone,
  // 3: vsync edge then hsync edge four pixels later
  task automatic sync_event(input int kind);
    ls_rise = 0; ls_hi = 0; fs_rise = 0; fs_hi = 0;
    @(negedge clk2x);
    case (kind)
      0: hs = 1'b0;
      1: begin hs = 1'b0; vs = 1'b0; end
      2: vs = 1'b0;
      default: begin vs = 1'b0; wait_cyc(8); hs = 1'b0; end
    endcase
    wait_cyc(8);
    hs = 1'b1; vs = 1'b1;
    wait_cyc(8);
  endtask

  // {kind[1:0], line_id[4:0], field[2:0], line pulses, field pulses}
  localparam logic [11:0] VEC [0:7] = '{
    {2'd1, 5'd0, 3'd1, 1'b1, 1'b1},
    {2'd0, 5'd1, 3'd1, 1'b1, 1'b0},
    {2'd0, 5'd2, 3'd1, 1'b1, 1'b0},
    {2'd2, 5'd2, 3'd1, 1'b0, 1'b0},
    {2'd3, 5'd3, 3'd1, 1'b1, 1'b0},
    {2'd1, 5'd0, 3'd2, 1'b1, 1'b1},
    {2'd0, 5'd1, 3'd2, 1'b1, 1'b0},
    {2'd2, 5'd1, 3'd2, 1'b0, 1'b0}
  };

  initial begin
    // R7 reset state
    wait_cyc(3);
    chk("R7 drive_en", int'(drv), 0);
    chk("R7 line_id", int'(line_id), 0);
    chk("R7 field", int'(field_num), 0);
    chk("R7 pix_en", int'(pix_en), 0);
    rst_n = 1'b1;
    @(negedge clk2x);
    chk("R7 drive_en after release", int'(drv), 1);
    chk("R1 pix_en first", int'(pix_en), 1);
    @(negedge clk2x);
    chk("R1 pix_en second", int'(pix_en), 0);
    wait_cyc(4);

    for (int v = 0; v < 8; v++) begin
      logic [11:0] e;
      e = VEC[v];
      sync_event(int'(e[11:10]));
      chk($sformatf("R2/R3/R4 vec%0d line_id", v), int'(line_id), int'(e[9:5]));
      chk($sformatf("R3/R4 vec%0d field", v), int'(field_num), int'(e[4:2]));
      chk($sformatf("R2 vec%0d line pulses", v), ls_rise, int'(e[1]));
      chk($sformatf("R2 vec%0d line pulse width", v), ls_hi, 2 * int'(e[1]));
      chk($sformatf("R3 vec%0d field pulses", v), fs_rise, int'(e[0]));
      chk($sformatf("R3 vec%0d field pulse width", v), fs_hi, 2 * int'(e[0]));
    end

    // R5 saturation: count is 1 now
    for (int i = 0; i < 29; i++) sync_event(0);
    chk("R5 line 30", int'(line_id), 30);
    sync_event(0);
    chk("R5 line 31", int'(line_id), 31);
    for (int i = 0; i < 10; i++) sync_event(0);
    chk("R5 line 41 saturates", int'(line_id), 31);

    // R6 wrap: field is 2 now
    for (int i = 0; i < 5; i++) sync_event(1);
    chk("R6 field 7", int'(field_num), 7);
    sync_event(1);
    chk("R6 wrap to 0", int'(field_num), 0);
    chk("R3 line 0 after field", int'(line_id), 0);
    sync_event(2);
    chk("R4 vsync alone keeps field", int'(field_num), 0);

    // R7 reset in mid-run
    sync_event(0);
    sync_event(1);
    rst_n = 1'b0;
    wait_cyc(2);
    chk("R7 mid reset drive_en", int'(drv), 0);
    chk("R7 mid reset line_id", int'(line_id), 0);
    chk("R7 mid reset field", int'(field_num), 0);
    rst_n = 1'b1;
    wait_cyc(4);
    sync_event(0);
    chk("R2 line after reset", int'(line_id), 1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule